// File: doc/BRIEF.md
# Relocatable Block-Erase Flash Controller with Program Verify

This block is a behavioural controller and storage model for a small flash array on a simple synchronous CPU bus. The array is 2 KB by default, organised as 16-bit words. It sits at a base address that software can move. Three registers in a fixed control window control it. A 13-bit base register holds address bits [23:11] of the array. It is split into a high part and a low part. A four-bit control register selects verify, erase, latch and enable behaviour.

Programming is a sequence. Software sets the latch bit, then writes a word into the array to capture its data and location. Software then raises the enable bit, which pulls the stored bits down to the captured data. To confirm the result, software sets verify together with latch. Array reads then return the stored word XORed with the captured data, so zero means the location is fully programmed. For an erase, software sets erase and latch and then writes to a selector address inside the array. Raising enable then sets every bit to 1 in one of eight sub-blocks, or in the whole array. A whole-array erase also wipes the non-volatile base-address defaults, which are reloaded at every reset.

Top module: `flash_array_ctl`

## Requirements
- R1: A bus access hits the array (`hit`=1) when `busSel`=1, the current base is reachable and `busAddr[23:11]` equals the base. A read drives `busRData` one cycle after the access and returns 0 when the access hit neither the array nor a register.
- R2: On `rstN`=0 the base register loads the shadow default. The shadow is set to `SHADOW_DEFAULT` by `porN`=0 and is not touched by `rstN`. Register window offsets are fixed: 0x0 holds the base high part, `ADDR[23:16]` in bits 7:0; 0x2 holds the base low part, `ADDR[15:11]` in bits 15:11; 0x4 is the control register.
- R3: A write to either base register takes effect only while `lockIn`=0 and `stopIn`=1. Any other write to these registers leaves the read-back value unchanged.
- R4: A base whose bits for `ADDR[23:20]` do not all equal its bit for `ADDR19` never produces a hit. Every other base does produce hits.
- R5: The control register resets to 0. Its bits are verify=3, erase=2, latch=1 and enable=0.
- R6: With verify=1, latch=1 and erase=0, an array read returns the stored word XOR the latched data, at any address in the array.
- R7: With verify=0, an array read returns the stored word unchanged.
- R8: With erase=1 and latch=1, an array write latches a selector taken from the address. Selector bit 5=1 with bit 1=0 picks sub-block `ADDR[4:2]`. The sub-block byte ranges, in 1/16ths of the array, are [0,1), [1,2), [2,3), [3,4), [4,6), [6,8), [8,12) and [12,16). A following 0-to-1 write of the enable bit sets every word of that sub-block to 0xFFFF and leaves the other words alone.
- R9: A selector with bit 5=0 erases every word of the array to 0xFFFF and sets all shadow bits to 1. At the next reset the base therefore reads as 0x00FF in the high register and 0xF800 in the low register.
- R10: With latch=1 and erase=0, an array write captures its data and word. A following 0-to-1 write of enable stores the stored word AND the captured data, so bits only go from 1 to 0.
- R11: A selector with bit 5=1 and bit 1=1 is reserved, and the enable edge that follows it erases nothing.
- R12: An array write with latch=0 changes nothing. An enable edge with no capture since the last operation changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of the registers |
| porN | input | 1 | Synchronous active-low power-on load of the shadow defaults |
| lockIn | input | 1 | Base relocation lock |
| stopIn | input | 1 | Stop state; relocation allowed only when 1 |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 24 | Byte address |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data, one cycle after the read |
| hit | output | 1 | Current access falls in the array |

## Verification
The bench uses the default parameters: a 24-bit bus, 11 offset bits (a 1024-word array), a shadow default that places the array at 0x001000, and the control window at 0xFFE400. These sizes let the bench reach real sub-block edges, such as the last word of sub-block 0 against the first word of sub-block 1. They also let it relocate the base into both an unreachable window and the top-of-memory reachable window. After a whole-array erase, a reset moves the array to 0xFFF800 through the erased shadow bits.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef struct packed {
    logic verify;
    logic erase;
    logic latch;
    logic enable;
  } flashCtrlT;

  typedef struct packed {
    logic       latchWr;
    logic       progGo;
    logic       eraseAll;
    logic       eraseBlk;
    logic [2:0] blkIdx;
    logic       arrRd;
    logic       verifyXor;
  } flashStbT;

  // sub-block edge k (0..8) in sixteenths of the array
  function automatic int unsigned blkEdge(input int unsigned k);
    if (k <= 4)      return k;
    else if (k == 5) return 6;
    else if (k == 6) return 8;
    else if (k == 7) return 12;
    else             return 16;
  endfunction

endpackage

// File: rtl/flash_ctl.sv
module flash_ctl
  import flash_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 11,
  parameter logic [ADDR_W-OFF_W-1:0] SHADOW_DEFAULT = 13'h0002,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 24'hFFE400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              lockIn,
  input  logic              stopIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic              hit,
  output logic [DATA_W-1:0] regRData,
  output logic              rdArr,
  output flashStbT          stb,
  output logic [OFF_W-2:0]  accIdx,
  output logic [OFF_W-2:0]  progIdx
);

  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int LO_W   = 16 - OFF_W;
  localparam int HI_W   = BASE_W - LO_W;

  logic [BASE_W-1:0] baseReg, shadowReg;
  flashCtrlT         ctrlReg;
  logic              latchValid;
  logic [5:1]        selAddr;
  logic [4:0]        topBits;
  logic              reachable, regSel, regWr, arrWr, baseWrOk, goEdge;
  logic [1:0]        regOff;

  assign topBits   = baseReg[BASE_W-1 -: 5];
  assign reachable = (&topBits) | ~(|topBits);
  assign hit       = busSel && reachable && (busAddr[ADDR_W-1:OFF_W] == baseReg);
  assign regSel    = busSel && (busAddr[ADDR_W-1:3] == CTRL_BASE[ADDR_W-1:3]);
  assign regOff    = busAddr[2:1];
  assign regWr     = regSel && busWr;
  assign arrWr     = hit && busWr;
  assign baseWrOk  = !lockIn && stopIn;
  assign accIdx    = busAddr[OFF_W-1:1];

  assign goEdge = regWr && (regOff == 2'd2) && busWData[0] && !ctrlReg.enable
                  && ctrlReg.latch && latchValid;

  always_comb begin
    stb           = '0;
    stb.latchWr   = arrWr && ctrlReg.latch && !ctrlReg.erase;
    stb.progGo    = goEdge && !ctrlReg.erase;
    stb.eraseAll  = goEdge && ctrlReg.erase && !selAddr[5];
    stb.eraseBlk  = goEdge && ctrlReg.erase && selAddr[5] && !selAddr[1];
    stb.blkIdx    = selAddr[4:2];
    stb.arrRd     = hit && !busWr;
    stb.verifyXor = ctrlReg.verify && ctrlReg.latch && !ctrlReg.erase;
  end

  // non-volatile defaults: only power-on load and whole-array erase touch them
  always_ff @(posedge clk) begin
    if (!porN)             shadowReg <= SHADOW_DEFAULT;
    else if (stb.eraseAll) shadowReg <= '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg    <= shadowReg;
      ctrlReg    <= '0;
      latchValid <= 1'b0;
      selAddr    <= '0;
      progIdx    <= '0;
      regRData   <= '0;
      rdArr      <= 1'b0;
    end else begin
      if (regWr && baseWrOk && regOff == 2'd0)
        baseReg[BASE_W-1 -: HI_W] <= busWData[HI_W-1:0];
      if (regWr && baseWrOk && regOff == 2'd1)
        baseReg[LO_W-1:0] <= busWData[DATA_W-1 -: LO_W];
      if (regWr && regOff == 2'd2)
        ctrlReg <= flashCtrlT'(busWData[3:0]);
      if (arrWr && ctrlReg.latch) begin
        latchValid <= 1'b1;
        if (ctrlReg.erase) selAddr <= busAddr[5:1];
        else               progIdx <= accIdx;
      end else if (goEdge) begin
        latchValid <= 1'b0;
      end
      rdArr    <= hit && !busWr;
      regRData <= '0;
      if (regSel && !busWr) begin
        case (regOff)
          2'd0:    regRData <= DATA_W'(baseReg[BASE_W-1 -: HI_W]);
          2'd1:    regRData <= {baseReg[LO_W-1:0], {(DATA_W-LO_W){1'b0}}};
          2'd2:    regRData <= DATA_W'(ctrlReg);
          default: regRData <= '0;
        endcase
      end
    end
  end

  AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !baseWrOk && regOff[1] == 1'b0) |=> $stable(baseReg)); // R3

  AST_NO_UNREACHABLE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (busAddr[ADDR_W-1 -: 4] == {4{busAddr[ADDR_W-5]}})); // R4

  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.progGo, stb.eraseAll, stb.eraseBlk})); // R8

endmodule

// File: rtl/flash_dp.sv
module flash_dp
  import flash_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 10,
  localparam int WORDS = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  flashStbT          stb,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic [IDX_W-1:0]  progIdx,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] latchData;
  int unsigned       blkLo, blkHi;

  assign blkLo = blkEdge(int'(stb.blkIdx)) * WORDS / 16;
  assign blkHi = blkEdge(int'(stb.blkIdx) + 1) * WORDS / 16;

  always_ff @(posedge clk) begin
    if (!rstN) latchData <= '0;
    else if (stb.latchWr) latchData <= wData;
  end

  always_ff @(posedge clk) begin
    if (stb.eraseAll || stb.eraseBlk) begin
      for (int i = 0; i < WORDS; i++) begin
        if (stb.eraseAll || (i >= int'(blkLo) && i < int'(blkHi)))
          mem[i] <= '1;
      end
    end else if (stb.progGo) begin
      mem[progIdx] <= mem[progIdx] & latchData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rData <= '0;
    else if (stb.arrRd) rData <= mem[accIdx] ^ (stb.verifyXor ? latchData : '0);
  end

  // checker state: word captured at the programming strobe
  logic [DATA_W-1:0] chkOld;
  logic [IDX_W-1:0]  chkIdx;
  logic [IDX_W-1:0]  chkBlkLo;
  always_ff @(posedge clk) begin
    chkOld   <= mem[progIdx];
    chkIdx   <= progIdx;
    chkBlkLo <= IDX_W'(blkLo);
  end

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    stb.progGo |=> ((mem[chkIdx] & ~chkOld) == '0)); // R10

  AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseAll |=> (mem[0] == '1 && mem[WORDS-1] == '1)); // R9

  AST_BLK_ERASED: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseBlk |=> (mem[chkBlkLo] == '1)); // R8

endmodule

// File: rtl/flash_array_ctl.sv
module flash_array_ctl
  import flash_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 11,
  parameter logic [ADDR_W-OFF_W-1:0] SHADOW_DEFAULT = 13'h0002,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 24'hFFE400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              lockIn,
  input  logic              stopIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              hit
);

  localparam int IDX_W = OFF_W - 1;

  flashStbT          stb;
  logic [IDX_W-1:0]  accIdx, progIdx;
  logic [DATA_W-1:0] regRData, arrRData;
  logic              rdArr;

  flash_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .SHADOW_DEFAULT(SHADOW_DEFAULT), .CTRL_BASE(CTRL_BASE)
  ) uCtl (
    .clk(clk), .rstN(rstN), .porN(porN), .lockIn(lockIn), .stopIn(stopIn),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .hit(hit), .regRData(regRData), .rdArr(rdArr), .stb(stb),
    .accIdx(accIdx), .progIdx(progIdx)
  );

  flash_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .accIdx(accIdx), .progIdx(progIdx),
    .wData(busWData), .rData(arrRData)
  );

  assign busRData = rdArr ? arrRData : regRData;

endmodule

// File: tb/tb_flash_array_ctl.sv
module tb_flash_array_ctl;

  localparam logic [23:0] CB  = 24'hFFE400;
  localparam logic [23:0] ARR = 24'h001000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, porN = 1'b0, lockIn = 1'b0, stopIn = 1'b1;
  logic busSel = 1'b0, busWr = 1'b0, hit;
  logic [23:0] busAddr = '0;
  logic [15:0] busWData = '0, busRData;

  flash_array_ctl dut (
    .clk(clk), .rstN(rstN), .porN(porN), .lockIn(lockIn), .stopIn(stopIn),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .hit(hit)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } itemT;

  itemT q[$];
  itemT mon;
  int   checks = 0, errors = 0;
  bit   rdFire = 1'b0, done = 1'b0;

  always @(posedge clk) rdFire <= busSel && !busWr && rstN;

  // monitor: one result per read, one cycle after the access
  always @(negedge clk) begin
    if (rdFire) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read result %h", busRData);
      end else begin
        mon = q.pop_front();
        if (busRData !== mon.exp) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", mon.tag, busRData, mon.exp);
        end
      end
    end
  end

  task automatic wr(input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rdHit(input logic [23:0] a, input logic expHit,
                       input logic [15:0] exp, input string tag);
    itemT it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    checks++;
    if (hit !== expHit) begin
      errors++;
      $display("FAIL %s: hit actual %b expected %b", tag, hit, expHit);
    end
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [15:0] exp, input string tag);
    itemT it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic prog(input logic [23:0] off, input logic [15:0] d);
    wr(CB + 24'd4, 16'h0002);
    wr(ARR + off, d);
    wr(CB + 24'd4, 16'h0003);
    wr(CB + 24'd4, 16'h0000);
  endtask

  task automatic eraseSel(input logic [23:0] selOff);
    wr(CB + 24'd4, 16'h0006);
    wr(ARR + selOff, 16'h0000);
    wr(CB + 24'd4, 16'h0007);
    wr(CB + 24'd4, 16'h0000);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;

    // reset state
    rd(CB + 24'd4, 16'h0000, "R5 control reset");
    rd(CB + 24'd0, 16'h0000, "R2 base high from shadow");
    rd(CB + 24'd2, 16'h1000, "R2 base low from shadow");

    // whole-array erase
    eraseSel(24'h000);
    rd(ARR + 24'h000, 16'hFFFF, "R9 erase all first word");
    rd(ARR + 24'h7FE, 16'hFFFF, "R9 erase all last word");
    rdHit(ARR + 24'h010, 1'b1, 16'hFFFF, "R1 hit inside array");
    rdHit(24'h001800, 1'b0, 16'h0000, "R1 miss above array");

    // program and verify
    wr(CB + 24'd4, 16'h0002);
    wr(ARR + 24'h010, 16'h1234);
    wr(CB + 24'd4, 16'h0003);
    wr(CB + 24'd4, 16'h0002);
    rd(ARR + 24'h010, 16'h1234, "R7 plain read");
    wr(CB + 24'd4, 16'h000A);
    rd(CB + 24'd4, 16'h000A, "R5 control bit layout");
    rd(ARR + 24'h010, 16'h0000, "R6 verify complete");
    rd(ARR + 24'h020, 16'hEDCB, "R6 verify other word");

    // second pass only clears bits
    wr(CB + 24'd4, 16'h0002);
    wr(ARR + 24'h010, 16'hFF00);
    wr(CB + 24'd4, 16'h0003);
    wr(CB + 24'd4, 16'h000A);
    rd(ARR + 24'h010, 16'hED00, "R10 verify after AND");
    wr(CB + 24'd4, 16'h0000);
    rd(ARR + 24'h010, 16'h1200, "R10 stored AND");

    // ignored writes and stale enable edge
    wr(ARR + 24'h010, 16'h0000);
    wr(CB + 24'd4, 16'h0002);
    wr(CB + 24'd4, 16'h0003);
    wr(CB + 24'd4, 16'h0000);
    rd(ARR + 24'h010, 16'h1200, "R12 no-latch write ignored");

    // sub-block erase
    prog(24'h07E, 16'h0000);
    prog(24'h080, 16'h0000);
    prog(24'h2FE, 16'h0000);
    prog(24'h300, 16'h0000);
    eraseSel(24'h024);
    rd(ARR + 24'h07E, 16'h0000, "R8 block0 kept");
    rd(ARR + 24'h080, 16'hFFFF, "R8 block1 erased");
    eraseSel(24'h034);
    rd(ARR + 24'h300, 16'hFFFF, "R8 block5 erased");
    rd(ARR + 24'h2FE, 16'h0000, "R8 block4 kept");

    // reserved selector
    prog(24'h080, 16'h0000);
    eraseSel(24'h026);
    rd(ARR + 24'h080, 16'h0000, "R11 reserved selector");
    rd(ARR + 24'h07E, 16'h0000, "R11 reserved selector other");

    // relocation gating
    lockIn = 1'b1;
    wr(CB + 24'd2, 16'h2000);
    rd(CB + 24'd2, 16'h1000, "R3 locked write ignored");
    lockIn = 1'b0; stopIn = 1'b0;
    wr(CB + 24'd2, 16'h2000);
    rd(CB + 24'd2, 16'h1000, "R3 not stopped write ignored");
    stopIn = 1'b1;
    wr(CB + 24'd2, 16'h2000);
    rd(CB + 24'd2, 16'h2000, "R3 relocation accepted");
    rdHit(24'h002010, 1'b1, 16'h1200, "R1 relocated hit");
    rdHit(24'h001010, 1'b0, 16'h0000, "R1 old window misses");

    // reachability
    wr(CB + 24'd0, 16'h0010);
    rdHit(24'h102010, 1'b0, 16'h0000, "R4 unreachable base");
    wr(CB + 24'd0, 16'h00FF);
    rdHit(24'hFF2010, 1'b1, 16'h1200, "R4 top window reachable");
    wr(CB + 24'd0, 16'h0000);

    // reset after whole-array erase: shadow erased
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(CB + 24'd0, 16'h00FF, "R9 erased shadow high");
    rd(CB + 24'd2, 16'hF800, "R9 erased shadow low");
    rd(CB + 24'd4, 16'h0000, "R5 control after reset");
    rdHit(24'hFFF810, 1'b1, 16'h1200, "R2 base from erased shadow");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads never returned", q.size());
    end
    finishRun();
  end

endmodule